// File: doc/BRIEF.md
# Receive Drop Diagnostic Counters

This block keeps two tallies of received frames that a receive DMA path had to throw away. It presents them in one 32-bit read-only status word. The first tally counts frames dropped because no receive descriptor or buffer was free to take them. The second tally counts frames lost to a receive FIFO overflow, and it also counts runt frames, which are good frames shorter than 64 bytes. Each tally has a sticky flag that records that it has wrapped.

The drop sources pulse their inputs for one clock per frame. The host sees the word at all times. The host asserts a read strobe for one cycle when it takes the word. On that cycle the word still shows the values being read. On the next edge both tallies and both flags return to zero. A drop that arrives in the same cycle as the read is not lost: it becomes the first count of the new period.

Top module: `rx_drop_diag`

## Requirements
- R1: After synchronous reset the whole status word reads 0x00000000.
- R2: Each cycle with `buf_miss_i` high adds one to the no-buffer tally in bits 15:0 on the next clock edge.
- R3: Each cycle with `fifo_ovf_i` high adds one to the FIFO-loss tally in bits 27:17.
- R4: Each cycle with `runt_i` high adds one to bits 27:17. If `fifo_ovf_i` and `runt_i` are high in the same cycle, the tally adds only one.
- R5: When an increment arrives while a tally is at all ones, that tally wraps to zero. The no-buffer tally then sets bit 16. The FIFO-loss tally then sets bit 28.
- R6: An overflow flag, once set, stays set while further events arrive, until the next read.
- R7: While `rd_i` is high, the word shows the values from before the read. On the next edge every count and flag field becomes zero.
- R8: A drop event in the same cycle as `rd_i` leaves that tally at 1 after the read, with its flag clear.
- R9: Bits 31:29 always read zero.
- R10: The two tallies are independent. Events to both in one cycle increment both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_miss_i | input | 1 | One-cycle pulse: frame dropped for lack of a descriptor or buffer |
| fifo_ovf_i | input | 1 | One-cycle pulse: frame lost to receive FIFO overflow |
| runt_i | input | 1 | One-cycle pulse: runt frame seen |
| rd_i | input | 1 | Host read strobe. Clears all fields on the following edge |
| stat_o | output | 32 | Packed status word |

## Verification
The bench drives the no-buffer tally through all 65536 steps and the FIFO-loss tally through all 2048 steps. This checks the wrap to zero and the setting of the flag. A design with an off-by-one terminal value would set the flag one event early or one event late. A design whose flag was not sticky would lose it on the next event.

The bench checks the read cycle itself as well as the cycle after it. A design that cleared the word too early would return zero to the host. A design that ignored an event arriving during the read would show 0 instead of 1 afterwards.

The bench also drives `fifo_ovf_i` and `runt_i` together, and it drives both tallies in the same cycle. These cases catch a design that double-counts the shared tally or lets one tally block the other.

// File: rtl/rx_drop_diag_pkg.sv
package rx_drop_diag_pkg;
  localparam int unsigned MISS_W_DEF = 16;
  localparam int unsigned FIFO_W_DEF = 11;
  localparam int unsigned WORD_W_DEF = 32;
endpackage

// File: rtl/drop_src_merge.sv
module drop_src_merge #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  output logic             hit_o
);
  // Several sources that land in the same cycle make a single increment.
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < N_SRC; i++) hit_o = hit_o | src_i[i];
  end

  // R4: any active source yields exactly one increment request
  a_r4_merge_single: assert property (@(posedge clk) disable iff (rst)
    ($countones(src_i) > 0) |-> hit_o);
  a_r4_merge_idle: assert property (@(posedge clk) disable iff (rst)
    (src_i == '0) |-> !hit_o);
endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= inc_i ? ONE : '0;
      ovf_o <= 1'b0;
    end else if (inc_i) begin
      cnt_o <= cnt_o + ONE;
      if (cnt_o == ALL_ONES) ovf_o <= 1'b1;
    end
  end

  // R2/R3: an increment without a clear advances by one, modulo 2^W
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i) |=> (cnt_o == $past(cnt_o) + ONE));
  // R5: a wrap sets the flag
  a_r5_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i && cnt_o == ALL_ONES) |=> (ovf_o && cnt_o == '0));
  // R6: the flag is sticky until a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !clr_i) |=> ovf_o);
  // R7: a clear with no event empties the counter and the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !inc_i) |=> (cnt_o == '0 && !ovf_o));
  // R8: an event in the clearing cycle becomes the first count
  a_r8_clear_inc: assert property (@(posedge clk) disable iff (rst)
    (clr_i && inc_i) |=> (cnt_o == ONE && !ovf_o));
  // R10: with no activity the counter holds its value
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !inc_i) |=> ($stable(cnt_o) && $stable(ovf_o)));
endmodule

// File: rtl/rx_drop_diag.sv
module rx_drop_diag
  import rx_drop_diag_pkg::*;
#(
  parameter int unsigned MISS_W = MISS_W_DEF,
  parameter int unsigned FIFO_W = FIFO_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_miss_i,
  input  logic              fifo_ovf_i,
  input  logic              runt_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] stat_o
);
  localparam int unsigned MISS_FLAG = MISS_W;
  localparam int unsigned FIFO_LSB  = MISS_W + 1;
  localparam int unsigned FIFO_FLAG = FIFO_LSB + FIFO_W;
  localparam int unsigned USED_W    = FIFO_FLAG + 1;

  logic [MISS_W-1:0] miss_cnt;
  logic              miss_ovf;
  logic [FIFO_W-1:0] fifo_cnt;
  logic              fifo_ovf;
  logic              fifo_hit;

  drop_src_merge #(.N_SRC(2)) u_fifo_merge (
    .clk   (clk),
    .rst   (rst),
    .src_i ({runt_i, fifo_ovf_i}),
    .hit_o (fifo_hit)
  );

  drop_counter #(.W(MISS_W)) u_miss_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (rd_i),
    .inc_i (buf_miss_i),
    .cnt_o (miss_cnt),
    .ovf_o (miss_ovf)
  );

  drop_counter #(.W(FIFO_W)) u_fifo_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (rd_i),
    .inc_i (fifo_hit),
    .cnt_o (fifo_cnt),
    .ovf_o (fifo_ovf)
  );

  generate
    if (USED_W < WORD_W) begin : g_pad
      assign stat_o = {{(WORD_W-USED_W){1'b0}}, fifo_ovf, fifo_cnt, miss_ovf, miss_cnt};
    end else begin : g_nopad
      assign stat_o = {fifo_ovf, fifo_cnt, miss_ovf, miss_cnt};
    end
  endgenerate

  // R9: the bits above the fields never rise
  generate
    if (USED_W < WORD_W) begin : g_rsv_chk
      a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        stat_o[WORD_W-1:USED_W] == '0);
    end
  endgenerate
  // R1: the cycle after reset shows an empty word
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (stat_o == '0));
endmodule

// File: tb/rx_drop_diag_tb_top.sv
`timescale 1ns/1ps
module rx_drop_diag_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        buf_miss_i = 1'b0;
  logic        fifo_ovf_i = 1'b0;
  logic        runt_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [31:0] stat_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  rx_drop_diag dut_i (
    .clk(clk), .rst(rst), .buf_miss_i(buf_miss_i), .fifo_ovf_i(fifo_ovf_i),
    .runt_i(runt_i), .rd_i(rd_i), .stat_o(stat_o)
  );

  // {miss, fifo, runt, rd, word expected after the edge}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {4'b1000, 32'h0000_0001},
    {4'b1000, 32'h0000_0002},
    {4'b0100, 32'h0002_0002},
    {4'b0010, 32'h0004_0002},
    {4'b0110, 32'h0006_0002},
    {4'b1100, 32'h0008_0003},
    {4'b0001, 32'h0000_0000},
    {4'b1001, 32'h0000_0001},
    {4'b0100, 32'h0002_0001},
    {4'b1101, 32'h0002_0001},
    {4'b0000, 32'h0002_0001},
    {4'b0001, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input logic m, input logic f, input logic r, input int n);
    @(negedge clk);
    buf_miss_i = m; fifo_ovf_i = f; runt_i = r;
    repeat (n) @(negedge clk);
    buf_miss_i = 1'b0; fifo_ovf_i = 1'b0; runt_i = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset word", stat_o, 32'h0);

    // vector walk: R2 R3 R4 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      buf_miss_i = VEC[i][35]; fifo_ovf_i = VEC[i][34];
      runt_i = VEC[i][33]; rd_i = VEC[i][32];
      @(negedge clk);
      buf_miss_i = 1'b0; fifo_ovf_i = 1'b0; runt_i = 1'b0; rd_i = 1'b0;
      check($sformatf("R2/R3/R4/R7/R8/R10 vec %0d", i), stat_o, VEC[i][31:0]);
      check("R9 reserved bits", {29'h0, stat_o[31:29]}, 32'h0);
    end

    // R5 no-buffer tally wrap
    hold(1'b1, 1'b0, 1'b0, 65535);
    check("R5 miss at all ones", stat_o, 32'h0000_FFFF);
    hold(1'b1, 1'b0, 1'b0, 1);
    check("R5 miss wrap sets bit16", stat_o, 32'h0001_0000);
    hold(1'b1, 1'b0, 1'b0, 1);
    check("R6 miss flag sticky", stat_o, 32'h0001_0001);

    // R7 read cycle shows old value, then clear
    @(negedge clk);
    rd_i = 1'b1;
    #1 check("R7 old value during read", stat_o, 32'h0001_0001);
    @(negedge clk);
    rd_i = 1'b0;
    check("R7 cleared after read", stat_o, 32'h0);

    // R5 FIFO-loss tally wrap via mixed sources
    hold(1'b0, 1'b1, 1'b0, 2047);
    check("R3 fifo at all ones", stat_o, 32'h0FFE_0000);
    hold(1'b0, 1'b0, 1'b1, 1);
    check("R5 fifo wrap sets bit28", stat_o, 32'h1000_0000);
    hold(1'b1, 1'b1, 1'b1, 2);
    check("R6 fifo flag sticky, R10 both", stat_o, 32'h1004_0002);
    check("R9 reserved after wrap", {29'h0, stat_o[31:29]}, 32'h0);

    // R8 with flags set: event during read restarts at one, flags clear
    @(negedge clk);
    rd_i = 1'b1; runt_i = 1'b1; buf_miss_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0; runt_i = 1'b0; buf_miss_i = 1'b0;
    check("R8 event in read cycle", stat_o, 32'h0002_0001);

    // R1 reset mid-run
    hold(1'b1, 1'b1, 1'b0, 3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", stat_o, 32'h0);
    do_read();
    check("R7 read of empty word", stat_o, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule